// File: doc/BRIEF.md
# Vector-Unit Devectorization Gating Controller

This controller decides, from observed instruction traffic, whether the vector execution unit should be powered or gated. It watches a stream of instructions and counts the vector instructions inside each fixed-length, non-overlapping window of instructions. At every window boundary, the total for that window is compared against two programmable thresholds. A low count gates the unit and tells the decoder to translate vector instructions into scalar micro-operations through its alternate path. A high count asks for power again.

While the unit is powering up, the controller keeps devectorization on. It hands control back to native vector decoding only when the power controller reports the unit ready. Counts that land between the two thresholds leave the decision untouched, which gives the gating hysteresis.

The block drives two outputs: a devectorize enable to the decoder and a power request to the vector unit. The scalar translation and the power switches are outside it.

Top module: `vecgate_ctrl`

## Requirements
- R1: After reset the controller is in the vector-on state: `devec_en_o`=0 and `pwr_req_o`=1. The state encoding at the ports is vector-on (devec 0, req 1), gated (devec 1, req 0) and waking (devec 1, req 1).
- R2: A window closes on the `win_len_i`-th cycle in which `insn_valid_i`=1. Its count is the number of those cycles that also have `insn_is_vec_i`=1. Cycles with `insn_valid_i`=0 neither advance the window nor count, whatever `insn_is_vec_i` is. Both counters restart at zero for the next window.
- R3: In vector-on, a window count strictly below `thr_lo_i` moves the controller to gated.
- R4: In gated, a window count strictly above `thr_hi_i` moves the controller to waking.
- R5: In waking, devectorization stays on until `unit_ready_i`=1 is sampled. The controller then moves to vector-on.
- R6: A window count c with `thr_lo_i` <= c <= `thr_hi_i` leaves the state unchanged. This assumes `thr_lo_i` < `thr_hi_i`.
- R7: In waking, a window count strictly below `thr_lo_i` aborts the wake and returns to gated. This takes priority over `unit_ready_i` sampled in the same cycle.
- R8: `unit_ready_i` has no effect in vector-on or gated.
- R9: The last instruction of a window is sampled at some rising edge. The resulting state change appears at the outputs after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| insn_valid_i | input | 1 | One instruction observed this cycle |
| insn_is_vec_i | input | 1 | The observed instruction is a vector instruction |
| win_len_i | input | LEN_W | Window length in instructions (at least 1) |
| thr_lo_i | input | LEN_W | Gating threshold |
| thr_hi_i | input | LEN_W | Wake threshold |
| unit_ready_i | input | 1 | Vector unit reports it is powered and usable |
| devec_en_o | output | 1 | Decoder translates vector instructions to scalar micro-ops |
| pwr_req_o | output | 1 | Power request to the vector unit |

## Verification
The bench sweeps every window length from 1 to 4 and every legal threshold pair for each length. It drives window counts on both sides of each threshold and exactly on it, so an off-by-one in a strict compare shows up as a transition one count too early or too late. Ready is raised in the very cycle a low-count window is evaluated during a wake. A design that favoured ready there would wrongly report vector-on with devectorization off. Idle cycles carrying a stray vector flag are placed inside windows; a counter that advanced on them would close windows early and change state at the wrong time. Lone ready pulses are sent in every state, which exposes a controller that leaves gated or vector-on on ready alone.

// File: rtl/vecgate_pkg.sv
package vecgate_pkg;
  typedef enum logic [1:0] {
    ST_VEC_ON = 2'd0,
    ST_GATED  = 2'd1,
    ST_WAKING = 2'd2
  } gate_state_e;
endpackage

// File: rtl/vecgate_window.sv
module vecgate_window #(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             insn_valid_i,
  input  logic             insn_is_vec_i,
  input  logic [LEN_W-1:0] win_len_i,
  output logic             win_done_o,
  output logic [LEN_W-1:0] win_cnt_o
);
  localparam int IDX_W = LEN_W + 1;

  logic [LEN_W-1:0] icnt_q, icnt_d;
  logic [LEN_W-1:0] vcnt_q, vcnt_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic [IDX_W-1:0] idx_next;
  logic [LEN_W-1:0] vcnt_inc;
  logic             close_win;

  always_comb begin
    idx_next  = {1'b0, icnt_q} + IDX_W'(1);
    vcnt_inc  = vcnt_q + LEN_W'(insn_is_vec_i);
    close_win = insn_valid_i && (idx_next >= {1'b0, win_len_i});
    icnt_d    = icnt_q;
    vcnt_d    = vcnt_q;
    cnt_d     = cnt_q;
    done_d    = close_win;
    if (insn_valid_i) begin
      if (close_win) begin
        icnt_d = '0;
        vcnt_d = '0;
        cnt_d  = vcnt_inc;
      end else begin
        icnt_d = idx_next[LEN_W-1:0];
        vcnt_d = vcnt_inc;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      icnt_q <= '0;
      vcnt_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (insn_valid_i) begin
        icnt_q <= icnt_d;
        vcnt_q <= vcnt_d;
      end
      if (close_win) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign win_done_o = done_q;
  assign win_cnt_o  = cnt_q;

  // R2
  vcnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vcnt_q <= icnt_q);

  // R2
  done_needs_insn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(insn_valid_i));
endmodule

// File: rtl/vecgate_fsm.sv
module vecgate_fsm
  import vecgate_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_done_i,
  input  logic [LEN_W-1:0] win_cnt_i,
  input  logic [LEN_W-1:0] thr_lo_i,
  input  logic [LEN_W-1:0] thr_hi_i,
  input  logic             unit_ready_i,
  output logic             devec_en_o,
  output logic             pwr_req_o
);
  gate_state_e state_q, state_d;
  logic        below_lo, above_hi;

  always_comb begin
    below_lo = win_done_i && (win_cnt_i < thr_lo_i);
    above_hi = win_done_i && (win_cnt_i > thr_hi_i);
    state_d  = state_q;
    unique case (state_q)
      ST_VEC_ON: if (below_lo) state_d = ST_GATED;
      ST_GATED:  if (above_hi) state_d = ST_WAKING;
      ST_WAKING: begin
        if (below_lo)          state_d = ST_GATED;
        else if (unit_ready_i) state_d = ST_VEC_ON;
      end
      default:   state_d = ST_VEC_ON;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_VEC_ON;
    else         state_q <= state_d;
  end

  assign devec_en_o = (state_q != ST_VEC_ON);
  assign pwr_req_o  = (state_q != ST_GATED);

  // R4
  no_gated_to_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GATED) |=> (state_q != ST_VEC_ON));

  // R3
  no_on_to_waking_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_VEC_ON) |=> (state_q != ST_WAKING));

  // R5
  hold_waking_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAKING && !unit_ready_i && !win_done_i) |=> (state_q == ST_WAKING));

  // R8
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_done_i && state_q != ST_WAKING) |=> $stable(state_q));

  // R7
  abort_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAKING && win_done_i && win_cnt_i < thr_lo_i) |=> (state_q == ST_GATED));
endmodule

// File: rtl/vecgate_ctrl.sv
module vecgate_ctrl #(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             insn_valid_i,
  input  logic             insn_is_vec_i,
  input  logic [LEN_W-1:0] win_len_i,
  input  logic [LEN_W-1:0] thr_lo_i,
  input  logic [LEN_W-1:0] thr_hi_i,
  input  logic             unit_ready_i,
  output logic             devec_en_o,
  output logic             pwr_req_o
);
  logic             win_done;
  logic [LEN_W-1:0] win_cnt;

  vecgate_window #(.LEN_W(LEN_W)) u_window (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .insn_valid_i (insn_valid_i),
    .insn_is_vec_i(insn_is_vec_i),
    .win_len_i    (win_len_i),
    .win_done_o   (win_done),
    .win_cnt_o    (win_cnt)
  );

  vecgate_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .win_done_i  (win_done),
    .win_cnt_i   (win_cnt),
    .thr_lo_i    (thr_lo_i),
    .thr_hi_i    (thr_hi_i),
    .unit_ready_i(unit_ready_i),
    .devec_en_o  (devec_en_o),
    .pwr_req_o   (pwr_req_o)
  );

  // R1
  never_off_and_native_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_req_o || devec_en_o);
endmodule

// File: tb/vecgate_ctrl_tb_top.sv
module vecgate_ctrl_tb_top;
  localparam int LEN_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             insn_valid, insn_is_vec, unit_ready;
  logic [LEN_W-1:0] win_len, thr_lo, thr_hi;
  logic             devec_en, pwr_req;

  int n_checks = 0;
  int n_fail   = 0;
  int ms;   // 0 vector-on, 1 gated, 2 waking

  always #5 clk = ~clk;

  vecgate_ctrl #(.LEN_W(LEN_W)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .insn_valid_i (insn_valid),
    .insn_is_vec_i(insn_is_vec),
    .win_len_i    (win_len),
    .thr_lo_i     (thr_lo),
    .thr_hi_i     (thr_hi),
    .unit_ready_i (unit_ready),
    .devec_en_o   (devec_en),
    .pwr_req_o    (pwr_req)
  );

  task automatic check_out(input string req);
    logic exp_dv, exp_rq;
    exp_dv = (ms != 0);
    exp_rq = (ms != 1);
    n_checks++;
    if (devec_en !== exp_dv || pwr_req !== exp_rq) begin
      n_fail++;
      $display("FAIL %s: devec/req actual %b%b expected %b%b", req, devec_en, pwr_req, exp_dv, exp_rq);
    end
  endtask

  // Feed one window of len instructions, first nvec of them vector; gaps put idle
  // cycles with a stray vector flag between instructions (R2). rdy raises ready
  // in the evaluation cycle (R7, R5). Checked after the following edge (R9).
  task automatic run_window(input int len, input int nvec, input bit gaps, input bit rdy,
                            input int lo, input int hi);
    for (int i = 0; i < len; i++) begin
      insn_valid  = 1'b1;
      insn_is_vec = (i < nvec);
      @(posedge clk); @(negedge clk);
      if (gaps) begin
        insn_valid  = 1'b0;
        insn_is_vec = 1'b1;
        if (i != len - 1) begin
          @(posedge clk); @(negedge clk);
          check_out("R2 no change inside window");
        end
      end
    end
    insn_valid  = 1'b0;
    insn_is_vec = 1'b0;
    unit_ready  = rdy;
    @(posedge clk); @(negedge clk);
    unit_ready  = 1'b0;
    case (ms)
      0: if (nvec < lo) ms = 1;
      1: if (nvec > hi) ms = 2;
      default: if (nvec < lo) ms = 1; else if (rdy) ms = 0;
    endcase
    check_out("R3/R4/R6/R7 window decision");
  endtask

  initial begin
    bit timed_out;
    timed_out   = 1'b0;
    rst_n       = 1'b0;
    insn_valid  = 1'b0;
    insn_is_vec = 1'b0;
    unit_ready  = 1'b0;
    win_len     = '0;
    thr_lo      = '0;
    thr_hi      = '0;
    fork
      begin
        for (int len = 1; len <= 4; len++) begin
          for (int lo = 0; lo < len; lo++) begin
            for (int hi = lo + 1; hi <= len; hi++) begin
              rst_n   = 1'b0;
              win_len = LEN_W'(len);
              thr_lo  = LEN_W'(lo);
              thr_hi  = LEN_W'(hi);
              @(negedge clk);
              ms = 0;
              check_out("R1 reset state");
              rst_n = 1'b1;
              @(negedge clk);
              for (int step = 0; step < 14; step++) begin
                int nv;
                nv = (step * 7 + lo * 3 + hi * 5) % (len + 1);
                run_window(len, nv, step % 2 == 1, step % 3 == 1, lo, hi);
                if (step % 4 == 3) begin
                  unit_ready = 1'b1;
                  @(posedge clk); @(negedge clk);
                  unit_ready = 1'b0;
                  if (ms == 2) ms = 0;
                  check_out("R5/R8 lone ready pulse");
                end
              end
              // Directed: reach waking, then low window with ready in the same cycle
              if (lo > 0) begin
                if (ms == 0) run_window(len, 0, 1'b0, 1'b0, lo, hi);
                if (ms == 1) run_window(len, len, 1'b0, 1'b0, lo, hi);
                if (ms == 2) run_window(len, 0, 1'b0, 1'b1, lo, hi);
              end
            end
          end
        end
      end
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule